// File: doc/BRIEF.md
# Authentication Step Delay Sequencer

This block paces the start of a link-protection authentication exchange on a display transmitter. When its enable is raised, it runs four bus actions in a fixed order. Each action is preceded by its own programmable wait, counted in millisecond ticks. Each action is handed to an external display-data-channel engine as a request, and that engine answers with an acknowledge. The sequencer moves on only after the acknowledge. When the last action has been acknowledged, the block reports that authentication is done. From then on it emits periodic link-integrity check requests. These fall on every N-th frame, on a programmable hsync within that frame.

Each wait is a 3-bit code taken from a fixed millisecond table. The check spacing is a 2-bit frame-count code, and the check position is a 3-bit hsync-offset code. The block does not contain the cipher, the bus transactions or the millisecond timebase: the millisecond timebase arrives as a one-cycle `ms_tick` pulse. Frame boundaries arrive as `frame_start` pulses and lines as `hsync_pulse` pulses.

Top module: `auth_step_timer`

## Requirements
- R1: After reset, `req_valid`, `auth_done` and `ri_check` are all low.
- R2: After `auth_en` rises, requests are issued in this order with these `req_op` codes: 0 = read receiver key, 1 = read receiver capabilities, 2 = write session random value, 3 = write transmitter key.
- R3: A delay code c maps to these millisecond counts: 0→0, 1→1, 2→2, 3→5, 4→10, 5→25, 6→50, 7→100. `req_valid` rises two cycles after the ms tick that completes the count. The count starts after the enable (step 0) or after the previous acknowledge, and counts only `ms_tick` pulses seen during the wait. For code 0, `req_valid` rises two cycles after the trigger.
- R4: Each step takes its wait from its own field: `dly_bksv_code` for op 0, `dly_bcaps_code` for op 1, `dly_an_code` for op 2 and `dly_aksv_code` for op 3.
- R5: `req_valid` and `req_op` hold steady until `req_ack` is seen with `req_valid`. A `req_ack` pulse while `req_valid` is low has no effect on the sequence or its timing.
- R6: `auth_done` goes high in the cycle after op 3 is acknowledged. No further request is issued while it is high.
- R7: `ri_interval_code` selects N: 00→128, 01→64, 10→32, 11→16 frames. Checks fall in frames N, 2N, and so on, where frames are counted by `frame_start` pulses from the moment `auth_done` rises.
- R8: `ri_offset_code` selects the hsync index P: 0→0, 1→8, 2→16, 3→32, 4→64, 5→128, 6→256, 7→512. Hsyncs are numbered from 0 after the frame's `frame_start`. `ri_check` is high in the cycle after hsync index P of a selected frame.
- R9: `ri_check` is a single-cycle pulse, at most once per selected frame. A selected frame with no more than P hsyncs produces no pulse.
- R10: While `auth_en` is low, the sequencer is idle from the next cycle on, with `req_valid`, `auth_done` and `ri_check` low. Raising it again restarts at op 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auth_en | input | 1 | Start and keep the sequence; low returns to idle |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| dly_bksv_code | input | 3 | Wait code before op 0 |
| dly_bcaps_code | input | 3 | Wait code before op 1 |
| dly_an_code | input | 3 | Wait code before op 2 |
| dly_aksv_code | input | 3 | Wait code before op 3 |
| ri_interval_code | input | 2 | Frame spacing code for integrity checks |
| ri_offset_code | input | 3 | Hsync offset code for integrity checks |
| frame_start | input | 1 | One-cycle pulse at each frame boundary |
| hsync_pulse | input | 1 | One-cycle pulse per line |
| req_ack | input | 1 | Acknowledge from the bus engine |
| req_valid | output | 1 | Request to the bus engine |
| req_op | output | 2 | Requested action code |
| auth_done | output | 1 | All four actions acknowledged |
| ri_check | output | 1 | Integrity check request pulse |

## Verification
A request is due two cycles after the ms tick that completes its wait. One cycle holds the register that reaches the count, and a second holds the state register. `ri_check` is due one cycle after the chosen hsync, and `auth_done` one cycle after the last acknowledge. The bench raises the enable and every acknowledge only in the cycle just after a tick, and it spaces ticks five cycles apart. As a result, the number of ticks seen between the trigger and the rise of `req_valid` is exactly the table value. The monitor compares that count, together with `req_op`, against the item the driver queued. The frame generator marks the cycle after each chosen hsync as expected. The monitor samples every falling edge, so a pulse that comes early, late or twice is caught.

// File: rtl/auth_seq_pkg.sv
package auth_seq_pkg;

  localparam int MS_W  = 7;   // holds up to 100 ms
  localparam int HS_W  = 10;  // holds up to 512 hsyncs
  localparam int FR_W  = 8;   // holds up to 128 frames
  localparam int OP_W  = 2;
  localparam int CODE_W = 3;

  typedef enum logic [1:0] {
    OP_BKSV  = 2'd0,
    OP_BCAPS = 2'd1,
    OP_AN    = 2'd2,
    OP_AKSV  = 2'd3
  } step_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_REQ  = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;

  // Nonlinear millisecond table for the step waits.
  function automatic logic [MS_W-1:0] delay_ms(input logic [CODE_W-1:0] code);
    logic [MS_W-1:0] v;
    case (code)
      3'd0: v = MS_W'(0);
      3'd1: v = MS_W'(1);
      3'd2: v = MS_W'(2);
      3'd3: v = MS_W'(5);
      3'd4: v = MS_W'(10);
      3'd5: v = MS_W'(25);
      3'd6: v = MS_W'(50);
      default: v = MS_W'(100);
    endcase
    return v;
  endfunction

  // Hsync offset: zero, then 8 doubling per step.
  function automatic logic [HS_W-1:0] hs_offset(input logic [CODE_W-1:0] code);
    logic [HS_W-1:0] v;
    if (code == '0) v = '0;
    else            v = HS_W'(8) << (code - CODE_W'(1));
    return v;
  endfunction

  // Frame spacing: 128 halved per code step.
  function automatic logic [FR_W-1:0] ri_frames(input logic [1:0] code);
    return FR_W'(128) >> code;
  endfunction

endpackage

// File: rtl/step_delay_timer.sv
module step_delay_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic [CNT_W-1:0] target,
  output logic             reached
);

  logic [CNT_W-1:0] elapsed_q;
  logic [CNT_W-1:0] elapsed_d;

  assign reached = (elapsed_q >= target);

  always_comb begin
    elapsed_d = elapsed_q;
    if (clear) begin
      elapsed_d = '0;
    end else if (tick && !reached) begin
      elapsed_d = elapsed_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) elapsed_q <= '0;
    else        elapsed_q <= elapsed_d;
  end

  // R3: the wait count never advances by more than one tick per cycle
  a_r3_one_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (elapsed_q == $past(elapsed_q)) || (elapsed_q == $past(elapsed_q) + CNT_W'(1)));

  // R3: the count only moves on a tick
  a_r3_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !clear && !tick |=> elapsed_q == $past(elapsed_q));

endmodule

// File: rtl/ri_check_sched.sv
module ri_check_sched
  import auth_seq_pkg::*;
#(
  parameter int FRM_W = FR_W,
  parameter int LIN_W = HS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [FRM_W-1:0] frames_n,
  input  logic [LIN_W-1:0] line_p,
  input  logic             frame_start,
  input  logic             hsync_pulse,
  output logic             ri_check
);

  logic [FRM_W-1:0] frm_q, frm_d;
  logic [LIN_W-1:0] hs_q, hs_d;
  logic             armed_q, armed_d;
  logic             pulse_q, pulse_d;
  logic             last_frame;

  assign last_frame = (frm_q == frames_n - FRM_W'(1));

  always_comb begin
    frm_d   = frm_q;
    hs_d    = hs_q;
    armed_d = armed_q;
    pulse_d = 1'b0;
    if (!run) begin
      frm_d   = '0;
      hs_d    = '0;
      armed_d = 1'b0;
    end else if (frame_start) begin
      hs_d    = '0;
      armed_d = last_frame;
      frm_d   = last_frame ? '0 : frm_q + FRM_W'(1);
    end else if (hsync_pulse && armed_q) begin
      if (hs_q == line_p) begin
        pulse_d = 1'b1;
        armed_d = 1'b0;
      end else begin
        hs_d = hs_q + LIN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_q   <= '0;
      hs_q    <= '0;
      armed_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      frm_q   <= frm_d;
      hs_q    <= hs_d;
      armed_q <= armed_d;
      pulse_q <= pulse_d;
    end
  end

  assign ri_check = pulse_q;

  // R9: a check request lasts one cycle
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ri_check |=> !ri_check);

  // R8: a check request follows an hsync
  a_r8_after_hsync: assert property (@(posedge clk) disable iff (!rst_n)
    ri_check |-> $past(hsync_pulse));

  // R10: no check request once the scheduler is stopped
  a_r10_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !ri_check);

endmodule

// File: rtl/auth_step_timer.sv
module auth_step_timer
  import auth_seq_pkg::*;
#(
  parameter int DLY_W = MS_W,
  parameter int LIN_W = HS_W,
  parameter int FRM_W = FR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auth_en,
  input  logic              ms_tick,
  input  logic [CODE_W-1:0] dly_bksv_code,
  input  logic [CODE_W-1:0] dly_bcaps_code,
  input  logic [CODE_W-1:0] dly_an_code,
  input  logic [CODE_W-1:0] dly_aksv_code,
  input  logic [1:0]        ri_interval_code,
  input  logic [CODE_W-1:0] ri_offset_code,
  input  logic              frame_start,
  input  logic              hsync_pulse,
  input  logic              req_ack,
  output logic              req_valid,
  output logic [OP_W-1:0]   req_op,
  output logic              auth_done,
  output logic              ri_check
);

  localparam logic [OP_W-1:0] LAST_STEP = OP_W'(OP_AKSV);

  // Asynchronous assert, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  seq_state_e      state_q, state_d;
  logic [OP_W-1:0] step_q, step_d;
  logic [CODE_W-1:0] cur_code;
  logic [DLY_W-1:0]  cur_target;
  logic              dly_reached;
  logic              ri_run;

  always_comb begin
    case (step_q)
      OP_W'(OP_BKSV):  cur_code = dly_bksv_code;
      OP_W'(OP_BCAPS): cur_code = dly_bcaps_code;
      OP_W'(OP_AN):    cur_code = dly_an_code;
      default:         cur_code = dly_aksv_code;
    endcase
    cur_target = DLY_W'(delay_ms(cur_code));
  end

  step_delay_timer #(.CNT_W(DLY_W)) u_wait (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .clear   (state_q != ST_WAIT),
    .tick    (ms_tick),
    .target  (cur_target),
    .reached (dly_reached)
  );

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    if (!auth_en) begin
      state_d = ST_IDLE;
      step_d  = '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          state_d = ST_WAIT;
          step_d  = '0;
        end
        ST_WAIT: begin
          if (dly_reached) state_d = ST_REQ;
        end
        ST_REQ: begin
          if (req_ack) begin
            if (step_q == LAST_STEP) begin
              state_d = ST_DONE;
            end else begin
              state_d = ST_WAIT;
              step_d  = step_q + OP_W'(1);
            end
          end
        end
        default: state_d = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  assign req_valid = (state_q == ST_REQ);
  assign req_op    = step_q;
  assign auth_done = (state_q == ST_DONE);
  assign ri_run    = auth_done && auth_en;

  ri_check_sched #(.FRM_W(FRM_W), .LIN_W(LIN_W)) u_ri (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .run         (ri_run),
    .frames_n    (FRM_W'(ri_frames(ri_interval_code))),
    .line_p      (LIN_W'(hs_offset(ri_offset_code))),
    .frame_start (frame_start),
    .hsync_pulse (hsync_pulse),
    .ri_check    (ri_check)
  );

  // R5: an unanswered request stays up with a steady op code
  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n_i)
    req_valid && !req_ack && auth_en |=> req_valid && $stable(req_op));

  // R3: a request only rises once the wait count was met
  a_r3_req_after_wait: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(req_valid) |-> $past(dly_reached));

  // R6: completion follows the acknowledged last step
  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(auth_done) |-> $past(req_valid && req_ack && (req_op == LAST_STEP)));

  // R10: disabling empties every output in the next cycle
  a_r10_disable: assert property (@(posedge clk) disable iff (!rst_n_i)
    !auth_en |=> !req_valid && !auth_done && !ri_check);

  // R9: check requests only while authenticated
  a_r9_ri_when_done: assert property (@(posedge clk) disable iff (!rst_n_i)
    ri_check |-> auth_done);

endmodule

// File: tb/auth_step_timer_tb_top.sv
module auth_step_timer_tb_top;

  logic       clk;
  logic       rst_n;
  logic       auth_en;
  logic       ms_tick;
  logic [2:0] c_bksv, c_bcaps, c_an, c_aksv;
  logic [1:0] ri_int;
  logic [2:0] ri_off;
  logic       frame_start;
  logic       hsync_pulse;
  logic       req_ack;
  logic       req_valid;
  logic [1:0] req_op;
  logic       auth_done;
  logic       ri_check;

  auth_step_timer dut_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .auth_en          (auth_en),
    .ms_tick          (ms_tick),
    .dly_bksv_code    (c_bksv),
    .dly_bcaps_code   (c_bcaps),
    .dly_an_code      (c_an),
    .dly_aksv_code    (c_aksv),
    .ri_interval_code (ri_int),
    .ri_offset_code   (ri_off),
    .frame_start      (frame_start),
    .hsync_pulse      (hsync_pulse),
    .req_ack          (req_ack),
    .req_valid        (req_valid),
    .req_op           (req_op),
    .auth_done        (auth_done),
    .ri_check         (ri_check)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  finished = 0;
  bit  mon_on = 0;
  bit  ri_exp = 0;
  int  ri_seen = 0;
  int  exp_op_q[$];
  int  exp_tk_q[$];
  int  tcount = 0;
  logic prev_req = 1'b0;
  logic prev_en  = 1'b0;

  function automatic int ms_of(input int c);
    int t[8] = '{0, 1, 2, 5, 10, 25, 50, 100};
    return t[c];
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Millisecond ticks, one cycle wide, five cycles apart.
  initial begin
    ms_tick = 1'b0;
    forever begin
      repeat (4) @(posedge clk);
      #1 ms_tick = 1'b1;
      @(posedge clk);
      #1 ms_tick = 1'b0;
    end
  end

  // Request monitor: pops the queued item on every rising request.
  always @(negedge clk) begin
    if (mon_on) begin
      if (req_valid && !prev_req) begin
        if (exp_op_q.size() == 0) begin
          chk(1'b0, "R2 unexpected request", int'(req_op), -1);
        end else begin
          int eo, et;
          eo = exp_op_q.pop_front();
          et = exp_tk_q.pop_front();
          chk(int'(req_op) == eo, "R2 step order", int'(req_op), eo);
          chk(tcount == et, "R3/R4 ticks before request", tcount, et);
        end
      end
      if (ms_tick) tcount++;
      if ((req_valid && req_ack) || (auth_en && !prev_en)) tcount = 0;
      if (ri_check) ri_seen++;
      if (ri_check !== ri_exp)
        chk(1'b0, "R8/R9 ri_check timing", int'(ri_check), int'(ri_exp));
      else if (ri_exp)
        chk(1'b1, "R8 ri_check on chosen hsync", 1, 1);
    end
    prev_req = req_valid;
    prev_en  = auth_en;
  end

  task automatic wait_after_tick();
    do @(negedge clk); while (!ms_tick);
    @(posedge clk);
    #1;
  endtask

  task automatic run_auth(input int a, input int b, input int c, input int d,
                          input bit stray);
    int codes[4];
    codes = '{a, b, c, d};
    c_bksv = 3'(a); c_bcaps = 3'(b); c_an = 3'(c); c_aksv = 3'(d);
    for (int k = 0; k < 4; k++) begin
      exp_op_q.push_back(k);
      exp_tk_q.push_back(ms_of(codes[k]));
    end
    wait_after_tick();
    auth_en = 1'b1;
    if (stray) begin
      // R5: an ack while no request is up must be ignored
      repeat (12) @(posedge clk);
      #1 req_ack = 1'b1;
      @(posedge clk);
      #1 req_ack = 1'b0;
    end
    for (int k = 0; k < 4; k++) begin
      do @(negedge clk); while (!req_valid);
      repeat (3) @(negedge clk);
      do @(negedge clk); while (!ms_tick);
      chk(req_valid === 1'b1, "R5 request held until ack", int'(req_valid), 1);
      chk(int'(req_op) == k, "R5 op stable until ack", int'(req_op), k);
      @(posedge clk);
      #1 req_ack = 1'b1;
      @(posedge clk);
      #1 req_ack = 1'b0;
    end
    @(negedge clk);
    chk(auth_done === 1'b1, "R6 done after last ack", int'(auth_done), 1);
    repeat (20) @(negedge clk);
    chk(req_valid === 1'b0, "R6 no request after done", int'(req_valid), 0);
  endtask

  task automatic run_frames(input int nfr, input int lines, input int n,
                            input int p, input bit live);
    for (int f = 1; f <= nfr; f++) begin
      @(posedge clk);
      #1 frame_start = 1'b1;
      @(posedge clk);
      #1 frame_start = 1'b0;
      for (int h = 0; h < lines; h++) begin
        bit hit;
        hit = live && (f % n == 0) && (h == p);
        hsync_pulse = 1'b1;
        @(posedge clk);
        #1 hsync_pulse = 1'b0;
        ri_exp = hit;
        @(posedge clk);
        #1 ri_exp = 1'b0;
      end
    end
  endtask

  task automatic ri_test(input int icode, input int pcode, input int nfr,
                         input int lines, input string tag);
    int n, p, want;
    n = 128 >> icode;
    p = (pcode == 0) ? 0 : (8 << (pcode - 1));
    want = (p < lines) ? (nfr / n) : 0;
    ri_int = 2'(icode);
    ri_off = 3'(pcode);
    @(posedge clk);
    #1 auth_en = 1'b0;
    repeat (3) @(posedge clk);
    run_auth(0, 0, 0, 0, 1'b0);
    ri_seen = 0;
    run_frames(nfr, lines, n, p, 1'b1);
    repeat (4) @(negedge clk);
    chk(ri_seen == want, tag, ri_seen, want);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; auth_en = 1'b0; req_ack = 1'b0;
    frame_start = 1'b0; hsync_pulse = 1'b0;
    c_bksv = '0; c_bcaps = '0; c_an = '0; c_aksv = '0;
    ri_int = '0; ri_off = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: quiet after reset
    chk(req_valid === 1'b0, "R1 req_valid after reset", int'(req_valid), 0);
    chk(auth_done === 1'b0, "R1 auth_done after reset", int'(auth_done), 0);
    chk(ri_check === 1'b0, "R1 ri_check after reset", int'(ri_check), 0);
    mon_on = 1;

    // R2, R3, R4: distinct codes on each step
    run_auth(1, 2, 3, 4, 1'b0);
    @(posedge clk); #1 auth_en = 1'b0;
    repeat (3) @(posedge clk);
    run_auth(5, 6, 7, 0, 1'b1);

    // R10: disable in the middle of a long wait, then restart at op 0
    @(posedge clk); #1 auth_en = 1'b0;
    repeat (3) @(posedge clk);
    c_bksv = 3'd7;
    wait_after_tick();
    auth_en = 1'b1;
    repeat (60) @(posedge clk);
    #1 auth_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(req_valid === 1'b0 && auth_done === 1'b0, "R10 idle after disable",
        int'(req_valid), 0);
    repeat (600) @(negedge clk);
    chk(req_valid === 1'b0, "R10 no request while disabled", int'(req_valid), 0);
    run_auth(0, 3, 0, 2, 1'b0);

    // R7, R8, R9: frame spacing and hsync offset
    ri_test(3, 7, 32, 520, "R7 sixteen-frame spacing at offset 512");
    ri_test(0, 0, 130, 4, "R7 128-frame spacing at offset 0");
    ri_test(2, 3, 33, 40, "R7 32-frame spacing at offset 32");
    ri_test(1, 5, 64, 100, "R9 short frame gives no check");

    // R10: disable stops the checks
    @(posedge clk); #1 auth_en = 1'b0;
    ri_seen = 0;
    ri_int = 2'd3; ri_off = 3'd0;
    run_frames(16, 3, 16, 0, 1'b0);
    repeat (4) @(negedge clk);
    chk(ri_seen == 0, "R10 no checks while disabled", ri_seen, 0);
    chk(exp_op_q.size() == 0, "R2 all queued requests seen", exp_op_q.size(), 0);

    finish_run();
  end

endmodule